// File: doc/BRIEF.md
# Interrupt Entry Stacking Sequencer

This block performs the state-saving part of interrupt entry for a byte-wide processor core. When the core acknowledges an interrupt, it pulses `ackValid` and presents its program counter, flag byte, code segment byte, stack pointer, interrupt segment byte, vector pointer and a segment-save enable. The block captures all of them in that cycle. It then writes the saved state onto a downward-growing system stack, one byte per cycle, through a simple memory write port.

After the pushes, the block reads the two bytes of the handler address from a vector table through a read port with one cycle of latency. It assembles the new program counter and reports completion with a one-cycle strobe. At that same strobe it handles the code segment. If saving was enabled, it asks the core to reload the code segment from the interrupt segment byte. If saving was disabled, it raises a segment override that stays up until the core signals a return from interrupt.

Top module: `intEntrySeq`

## Requirements
- R1: During and right after reset, `busy`, `done`, `stkWrEn`, `vecRdEn`, `codeSegLoad` and `segOverride` are all low.
- R2: The first stack write puts the low byte of the captured PC at address SP-1. The second puts the high byte at SP-2, where SP is `spIn` at acknowledge. The stack pointer drops by one before each byte is written.
- R3: When `segSaveEn` was 1 at acknowledge, the third write puts the code segment byte at SP-3 and the fourth puts the flag byte at SP-4. At `done`, `spOut` equals SP-4.
- R4: When `segSaveEn` was 0 at acknowledge, no code segment byte is written. The third and last write puts the flag byte at SP-3, and at `done` `spOut` equals SP-3.
- R5: After the last push, the block reads the vector high byte at address {VEC_PAGE, ivr} and then the low byte at that address plus one, in consecutive cycles. `vecRdData` carries each byte one cycle after its request. No read and write are ever active in the same cycle.
- R6: `done` is high for exactly one cycle. In that cycle `newPc` equals {high byte, low byte} of the vector that was read.
- R7: With segment saving enabled, `codeSegLoad` is high only in the `done` cycle, with `codeSegOut` equal to the captured `isrIn`. `segOverride` stays low.
- R8: With segment saving disabled, `segOverride` rises in the cycle after `done`. It stays high until a cycle in which `iretIn` is high, and is low from the following cycle on.
- R9: `busy` is high from the cycle after an accepted acknowledge through the `done` cycle. An acknowledge seen while `busy` is high causes no stack write, read or result of its own.
- R10: `busy` lasts 8 cycles per sequence with segment saving enabled and 7 with it disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| ackValid | input | 1 | Interrupt acknowledge strobe |
| pcIn | input | 16 | Program counter at acknowledge |
| flagsIn | input | 8 | Flag byte at acknowledge |
| codeSegIn | input | 8 | Code segment byte at acknowledge |
| segSaveEn | input | 1 | Enable saving and reloading the code segment |
| isrIn | input | 8 | Interrupt segment byte |
| ivrIn | input | 8 | Vector table pointer (low address byte) |
| spIn | input | 16 | Stack pointer at acknowledge |
| iretIn | input | 1 | Return-from-interrupt strobe, clears the override |
| stkWrEn | output | 1 | Stack write enable |
| stkWrAddr | output | 16 | Stack write address |
| stkWrData | output | 8 | Stack write data |
| vecRdEn | output | 1 | Vector read request |
| vecRdAddr | output | 16 | Vector read address |
| vecRdData | input | 8 | Vector read data, one cycle after request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| newPc | output | 16 | Loaded program counter |
| spOut | output | 16 | Current stack pointer |
| codeSegLoad | output | 1 | Reload code segment from codeSegOut |
| codeSegOut | output | 8 | Value to load into the code segment |
| segOverride | output | 1 | Interrupt segment used in place of code segment |

## Verification
The assertions assume that the vector read port returns its byte exactly one cycle after the request. They also assume that `iretIn` is never pulsed in the same cycle as `done`, since that pairing would make the override hold look broken. The bench's memory model meets the latency assumption by registering its read data on the edge after each request. It drives `iretIn` only after the result of a sequence has been checked. The bench also holds `ackValid` high through several busy cycles, with different input values, to probe that acknowledges are ignored while a sequence is running.

// File: rtl/intSeqPkg.sv
package intSeqPkg;

  typedef enum logic [1:0] {
    SRC_PCL = 2'd0,
    SRC_PCH = 2'd1,
    SRC_CS  = 2'd2,
    SRC_FLG = 2'd3
  } pushSrcT;

  typedef struct packed {
    logic    capture;
    logic    push;
    pushSrcT pushSrc;
    logic    rdHi;
    logic    rdLo;
    logic    latchHi;
    logic    latchLo;
    logic    finish;
  } ctrlStrobeT;

endpackage

// File: rtl/intSeqCtrl.sv
module intSeqCtrl
  import intSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackValid,
  input  logic       segSaveEn,
  output ctrlStrobeT strobe,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_PCL, S_PCH, S_CS, S_FLG, S_RDHI, S_RDLO, S_WAIT, S_DONE
  } stateT;

  stateT stateQ, stateD;
  logic  saveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      saveQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == S_IDLE && ackValid) saveQ <= segSaveEn;
    end
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    strobe.pushSrc = SRC_PCL;
    unique case (stateQ)
      S_IDLE: begin
        strobe.capture = ackValid;
        if (ackValid) stateD = S_PCL;
      end
      S_PCL: begin
        strobe.push = 1'b1;
        strobe.pushSrc = SRC_PCL;
        stateD = S_PCH;
      end
      S_PCH: begin
        strobe.push = 1'b1;
        strobe.pushSrc = SRC_PCH;
        stateD = saveQ ? S_CS : S_FLG;
      end
      S_CS: begin
        strobe.push = 1'b1;
        strobe.pushSrc = SRC_CS;
        stateD = S_FLG;
      end
      S_FLG: begin
        strobe.push = 1'b1;
        strobe.pushSrc = SRC_FLG;
        stateD = S_RDHI;
      end
      S_RDHI: begin
        strobe.rdHi = 1'b1;
        stateD = S_RDLO;
      end
      S_RDLO: begin
        strobe.rdLo = 1'b1;
        strobe.latchHi = 1'b1;
        stateD = S_WAIT;
      end
      S_WAIT: begin
        strobe.latchLo = 1'b1;
        stateD = S_DONE;
      end
      S_DONE: begin
        strobe.finish = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);
  assign done = (stateQ == S_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy); // R9

endmodule

// File: rtl/intSeqDatapath.sv
module intSeqDatapath
  import intSeqPkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned VEC_PAGE = 0,
  localparam int unsigned PC_W    = 2 * DATA_W,
  localparam int unsigned PAGE_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [DATA_W-1:0] flagsIn,
  input  logic [DATA_W-1:0] codeSegIn,
  input  logic              segSaveEn,
  input  logic [DATA_W-1:0] isrIn,
  input  logic [DATA_W-1:0] ivrIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic              iretIn,
  input  logic [DATA_W-1:0] vecRdData,
  output logic              stkWrEn,
  output logic [ADDR_W-1:0] stkWrAddr,
  output logic [DATA_W-1:0] stkWrData,
  output logic              vecRdEn,
  output logic [ADDR_W-1:0] vecRdAddr,
  output logic [PC_W-1:0]   newPc,
  output logic [ADDR_W-1:0] spOut,
  output logic              codeSegLoad,
  output logic [DATA_W-1:0] codeSegOut,
  output logic              segOverride
);

  localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(VEC_PAGE);

  logic [PC_W-1:0]   pcQ, newPcQ;
  logic [DATA_W-1:0] flagsQ, csQ, isrQ, ivrQ, vecHiQ;
  logic [ADDR_W-1:0] spQ;
  logic              saveQ, ovrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= '0;
      flagsQ <= '0;
      csQ    <= '0;
      isrQ   <= '0;
      ivrQ   <= '0;
      spQ    <= '0;
      saveQ  <= 1'b0;
      vecHiQ <= '0;
      newPcQ <= '0;
    end else begin
      if (strobe.capture) begin
        pcQ    <= pcIn;
        flagsQ <= flagsIn;
        csQ    <= codeSegIn;
        isrQ   <= isrIn;
        ivrQ   <= ivrIn;
        spQ    <= spIn;
        saveQ  <= segSaveEn;
      end else if (strobe.push) begin
        spQ <= spQ - ADDR_W'(1);
      end
      if (strobe.latchHi) vecHiQ <= vecRdData;
      if (strobe.latchLo) newPcQ <= {vecHiQ, vecRdData};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        ovrQ <= 1'b0;
    else if (strobe.finish && !saveQ) ovrQ <= 1'b1;
    else if (iretIn)                  ovrQ <= 1'b0;
  end

  always_comb begin
    unique case (strobe.pushSrc)
      SRC_PCL: stkWrData = pcQ[DATA_W-1:0];
      SRC_PCH: stkWrData = pcQ[PC_W-1:DATA_W];
      SRC_CS:  stkWrData = csQ;
      default: stkWrData = flagsQ;
    endcase
  end

  assign stkWrEn     = strobe.push;
  assign stkWrAddr   = spQ - ADDR_W'(1);
  assign vecRdEn     = strobe.rdHi | strobe.rdLo;
  assign vecRdAddr   = {PAGE, ivrQ} + ADDR_W'(strobe.rdLo);
  assign newPc       = newPcQ;
  assign spOut       = spQ;
  assign codeSegLoad = strobe.finish && saveQ;
  assign codeSegOut  = isrQ;
  assign segOverride = ovrQ;

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    segOverride && !iretIn |=> segOverride); // R8
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    segOverride && iretIn && !strobe.finish |=> !segOverride); // R8

endmodule

// File: rtl/intEntrySeq.sv
module intEntrySeq
  import intSeqPkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned VEC_PAGE = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ackValid,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   flagsIn,
  input  logic [DATA_W-1:0]   codeSegIn,
  input  logic                segSaveEn,
  input  logic [DATA_W-1:0]   isrIn,
  input  logic [DATA_W-1:0]   ivrIn,
  input  logic [ADDR_W-1:0]   spIn,
  input  logic                iretIn,
  output logic                stkWrEn,
  output logic [ADDR_W-1:0]   stkWrAddr,
  output logic [DATA_W-1:0]   stkWrData,
  output logic                vecRdEn,
  output logic [ADDR_W-1:0]   vecRdAddr,
  input  logic [DATA_W-1:0]   vecRdData,
  output logic                busy,
  output logic                done,
  output logic [2*DATA_W-1:0] newPc,
  output logic [ADDR_W-1:0]   spOut,
  output logic                codeSegLoad,
  output logic [DATA_W-1:0]   codeSegOut,
  output logic                segOverride
);

  ctrlStrobeT strobe;

  intSeqCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ackValid  (ackValid),
    .segSaveEn (segSaveEn),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  intSeqDatapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .VEC_PAGE (VEC_PAGE)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pcIn        (pcIn),
    .flagsIn     (flagsIn),
    .codeSegIn   (codeSegIn),
    .segSaveEn   (segSaveEn),
    .isrIn       (isrIn),
    .ivrIn       (ivrIn),
    .spIn        (spIn),
    .iretIn      (iretIn),
    .vecRdData   (vecRdData),
    .stkWrEn     (stkWrEn),
    .stkWrAddr   (stkWrAddr),
    .stkWrData   (stkWrData),
    .vecRdEn     (vecRdEn),
    .vecRdAddr   (vecRdAddr),
    .newPc       (newPc),
    .spOut       (spOut),
    .codeSegLoad (codeSegLoad),
    .codeSegOut  (codeSegOut),
    .segOverride (segOverride)
  );

  AST_NO_RD_ON_WR: assert property (@(posedge clk) disable iff (!rstN)
    stkWrEn |-> !vecRdEn); // R5
  AST_CSLOAD_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    codeSegLoad |-> done && !segOverride); // R7
  AST_NO_WORK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stkWrEn && !vecRdEn && !done); // R9

endmodule

// File: tb/test_intEntrySeq.sv
module test_intEntrySeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ackValid = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0]  flagsIn = '0, codeSegIn = '0, isrIn = '0, ivrIn = '0;
  logic        segSaveEn = 1'b0, iretIn = 1'b0;
  logic [15:0] spIn = '0;
  logic        stkWrEn, vecRdEn, busy, done, codeSegLoad, segOverride;
  logic [15:0] stkWrAddr, vecRdAddr, newPc, spOut;
  logic [7:0]  stkWrData, codeSegOut;
  logic [7:0]  vecRdData = '0;

  int checks = 0, fails = 0;
  logic [23:0] wrQ[$];
  logic [15:0] expPcQ[$];
  logic [15:0] expSpQ[$];
  logic        expSaveQ[$];
  logic [7:0]  expIsrQ[$];
  logic [4:0]  expLenQ[$];
  logic [15:0] expRdQ[$];
  int busyCnt = 0;

  always #2 clk = ~clk;

  intEntrySeq i_intEntrySeq (.*);

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd3 + 8'h11) ^ a[15:8];
  endfunction

  always @(posedge clk) if (vecRdEn) vecRdData <= memByte(vecRdAddr);

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run hung: actual running, expected finished");
    finishRun();
  end

  // Monitor: pops expected items as the design produces them
  always @(negedge clk) if (rstN) begin
    if (busy) busyCnt++;
    if (stkWrEn) begin
      if (wrQ.size() == 0)
        chk(1'b0, "R9", $sformatf("unexpected write actual %h:%h expected none", stkWrAddr, stkWrData));
      else begin
        logic [23:0] e;
        e = wrQ.pop_front();
        chk({stkWrAddr, stkWrData} == e, "R2/R3/R4",
            $sformatf("stack write actual %h expected %h", {stkWrAddr, stkWrData}, e));
      end
    end
    if (vecRdEn) begin
      if (expRdQ.size() == 0)
        chk(1'b0, "R5", $sformatf("unexpected read actual %h expected none", vecRdAddr));
      else begin
        logic [15:0] ra;
        ra = expRdQ.pop_front();
        chk(vecRdAddr == ra, "R5", $sformatf("read addr actual %h expected %h", vecRdAddr, ra));
      end
    end
    if (done) begin
      if (expPcQ.size() == 0)
        chk(1'b0, "R9", "unexpected done actual 1 expected 0");
      else begin
        logic [15:0] ep, es;
        logic sv;
        logic [7:0] ei;
        logic [4:0] el;
        ep = expPcQ.pop_front(); es = expSpQ.pop_front();
        sv = expSaveQ.pop_front(); ei = expIsrQ.pop_front(); el = expLenQ.pop_front();
        chk(newPc == ep, "R6", $sformatf("newPc actual %h expected %h", newPc, ep));
        chk(spOut == es, sv ? "R3" : "R4", $sformatf("spOut actual %h expected %h", spOut, es));
        chk(codeSegLoad == sv, "R7", $sformatf("codeSegLoad actual %b expected %b", codeSegLoad, sv));
        if (sv) chk(codeSegOut == ei, "R7", $sformatf("codeSegOut actual %h expected %h", codeSegOut, ei));
        chk(segOverride == 1'b0, "R7", $sformatf("override at done actual %b expected 0", segOverride));
        chk(busyCnt == int'(el), "R10", $sformatf("busy length actual %0d expected %0d", busyCnt, el));
      end
      busyCnt = 0;
    end
  end

  // Driver: push expected items, then stimulate
  task automatic runSeq(input logic [15:0] pc, input logic [7:0] fl, input logic [7:0] cs,
                        input logic sv, input logic [7:0] ivr, input logic [15:0] sp,
                        input logic [7:0] isr, input int extraAck);
    logic [15:0] va;
    va = {8'h00, ivr};
    wrQ.push_back({sp - 16'd1, pc[7:0]});
    wrQ.push_back({sp - 16'd2, pc[15:8]});
    if (sv) wrQ.push_back({sp - 16'd3, cs});
    wrQ.push_back({sp - (sv ? 16'd4 : 16'd3), fl});
    expRdQ.push_back(va);
    expRdQ.push_back(va + 16'd1);
    expPcQ.push_back({memByte(va), memByte(va + 16'd1)});
    expSpQ.push_back(sp - (sv ? 16'd4 : 16'd3));
    expSaveQ.push_back(sv);
    expIsrQ.push_back(isr);
    expLenQ.push_back(sv ? 5'd8 : 5'd7);
    @(negedge clk);
    pcIn = pc; flagsIn = fl; codeSegIn = cs; segSaveEn = sv;
    ivrIn = ivr; spIn = sp; isrIn = isr; ackValid = 1'b1;
    @(negedge clk);
    for (int i = 0; i < extraAck; i++) begin
      // R9: change inputs while busy; must be ignored
      pcIn = ~pc; spIn = sp ^ 16'h0F0F; segSaveEn = ~sv; ivrIn = ivr + 8'd7;
      @(negedge clk);
    end
    ackValid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    #1;
    chk(segOverride == !sv, "R8", $sformatf("override after done actual %b expected %b", segOverride, !sv));
    if (!sv) begin
      repeat (2) @(negedge clk);
      chk(segOverride == 1'b1, "R8", $sformatf("override held actual %b expected 1", segOverride));
      iretIn = 1'b1;
      @(negedge clk);
      iretIn = 1'b0;
      chk(segOverride == 1'b0, "R8", $sformatf("override after iret actual %b expected 0", segOverride));
    end
    chk(busy == 1'b0, "R9", $sformatf("busy after sequence actual %b expected 0", busy));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, stkWrEn, vecRdEn, codeSegLoad, segOverride} == 6'b0, "R1",
        $sformatf("reset outputs actual %b expected 000000",
                  {busy, done, stkWrEn, vecRdEn, codeSegLoad, segOverride}));
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && stkWrEn == 1'b0, "R1",
        $sformatf("after reset busy/wr actual %b%b expected 00", busy, stkWrEn));
    runSeq(16'h1234, 8'hA5, 8'h3C, 1'b1, 8'h20, 16'h0200, 8'h77, 0);
    runSeq(16'hBEEF, 8'h5A, 8'hC3, 1'b0, 8'h40, 16'h0100, 8'h66, 0);
    runSeq(16'h00FF, 8'h01, 8'h02, 1'b1, 8'hFE, 16'h0003, 8'h99, 4);
    runSeq(16'hFF00, 8'h80, 8'h7F, 1'b0, 8'h10, 16'h0002, 8'h12, 5);
    runSeq(16'h8001, 8'hFF, 8'h00, 1'b1, 8'h00, 16'h0000, 8'hAB, 0);
    repeat (4) @(negedge clk);
    chk(wrQ.size() == 0 && expPcQ.size() == 0 && expRdQ.size() == 0, "R9",
        $sformatf("leftover expected items actual %0d expected 0",
                  wrQ.size() + expPcQ.size() + expRdQ.size()));
    finishRun();
  end

endmodule